// File: doc/BRIEF.md
# Two-Channel System Timer

This block is a memory-mapped system timer with two counting channels driven from one clock. The event channel is a one-shot timer. Software loads a compare value, clears the counter and enables the channel. The counter then climbs until it equals the compare value, raises a compare flag and holds there. While the flag is set and not masked, an interrupt line is high. The time-base channel is a free-running 64-bit counter. Its low word is read at one address. Reading the low word captures the high word into a buffer, so a later read of the buffer returns a consistent pair.

Each channel has its own prescaler, which divides the clock by 1, 4 or 16. Each channel is switched on and off through a write-one-to-set register and a write-one-to-clear register. Each counter is zeroed through a self-clearing clear register. A simple register bus carries address, write data, a write strobe and a read strobe. Read data is combinational while the read strobe is high and is zero otherwise.

The event channel is a state machine with three states. EV_OFF is the disabled state. EV_RUN counts on prescaler ticks. EV_DONE means the compare value was reached and the counter holds. The transitions are:
- ENABLE: EV_OFF to EV_RUN.
- MATCH: EV_RUN to EV_DONE.
- RESTART: a counter clear in EV_RUN or EV_DONE leads to EV_RUN.
- DISABLE: any state to EV_OFF.

The time-base channel has two states, FR_OFF and FR_RUN, with the transitions ENABLE and DISABLE.

Top module: `os_timer_duo`

## Requirements
- R1: After reset, the clock control register reads 0, the flag reads 0 and the mask reads 1. The enable status reads 0, both counters read 0 and `irq` is low.
- R2: The register map uses these byte addresses:
  - 0x00: clock control.
  - 0x08: counter clear (reads 0).
  - 0x0C: flag.
  - 0x10: mask.
  - 0x14: compare value.
  - 0x18: event counter.
  - 0x20: time-base low word.
  - 0x24: high-word buffer.
  - 0x34: enable set (reads as enable status).
  - 0x38: enable clear (reads 0).

  Any other address reads 0, and a write to it changes nothing.
- R3: Clock control bits [1:0] select the event-channel prescaler and bits [3:2] select the time-base prescaler. Code 0 divides by 1, code 1 by 4, and codes 2 and 3 by 16. A counter that is enabled or cleared at edge E reads floor(n/div) + its start value n edges later.
- R4: Writing 1 to bit 0 or bit 1 at 0x34 enables the event or time-base channel. Writing 1 to the same bit at 0x38 disables it. Zero bits have no effect. Status bit 0 is the event channel and bit 1 is the time-base channel.
- R5: Writing 1 to bit 0 or bit 1 at 0x08 zeroes the event or time-base counter and restarts its prescaler. A clear takes priority over a count in the same cycle.
- R6: In EV_RUN, the flag sets at the edge after the counter equals the compare value. The state goes to EV_DONE and the counter holds from then on.
- R7: Writing 0 to flag bit 0 clears the flag and writing 1 leaves it unchanged. When a compare match and a clearing write fall on the same edge, the flag ends up set.
- R8: `irq` is high exactly when the flag is 1 and mask bit 0 is 0.
- R9: The time-base channel counts modulo 2^64. A read strobe at 0x20 returns the low word and copies the high word into the buffer at that edge. 0x24 returns the buffer.
- R10: DISABLE freezes the event counter. A later ENABLE resumes counting from the held value. RESTART from EV_DONE resumes counting from zero, and the next match sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, zero while `bus_rd` is low |
| irq | output | 1 | Event-channel interrupt, flag and not masked |

## Verification
Two pairs of functions can land on the same edge.

The first pair is a counter clear and a prescaler tick. The bench runs a channel at divide-by-1, so every edge ticks, then writes its clear bit. It reads the counter right after the clearing edge and expects 0; a count would have left 1.

The second pair is a compare match and a software write that clears the flag. The bench enables the event channel with a known compare value and counts edges so that the flag-clearing write lands on the matching edge. It then expects `irq` high, because the set wins.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

    // byte offsets of the register map
    localparam int unsigned OFS_CTRL  = 32'h00;
    localparam int unsigned OFS_CLR   = 32'h08;
    localparam int unsigned OFS_FLAG  = 32'h0C;
    localparam int unsigned OFS_MASK  = 32'h10;
    localparam int unsigned OFS_CMP   = 32'h14;
    localparam int unsigned OFS_EVCNT = 32'h18;
    localparam int unsigned OFS_TBLO  = 32'h20;
    localparam int unsigned OFS_TBHI  = 32'h24;
    localparam int unsigned OFS_ESET  = 32'h34;
    localparam int unsigned OFS_ECLR  = 32'h38;

    localparam int unsigned NUM_CH   = 2;
    localparam int unsigned CODE_W   = 2;
    localparam int unsigned CH_EVENT = 0;
    localparam int unsigned CH_TBASE = 1;

    typedef enum logic [1:0] {
        EV_OFF  = 2'd0,
        EV_RUN  = 2'd1,
        EV_DONE = 2'd2
    } ev_state_t;

    typedef enum logic {
        FR_OFF = 1'b0,
        FR_RUN = 1'b1
    } fr_state_t;

    // last phase value of a prescaler: div = 4**min(code,2)
    function automatic int unsigned div_limit(input int unsigned code);
        int unsigned sh;
        sh = (code > 2) ? 2 : code;
        return (32'd1 << (2 * sh)) - 1;
    endfunction

endpackage

// File: rtl/ostmr_prescaler.sv
module ostmr_prescaler #(
    parameter int unsigned CODE_W = 2,
    parameter int unsigned PH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    import ostmr_pkg::*;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] limit;

    always_comb begin
        limit = PH_W'(div_limit(32'(code)));
        tick  = run && (phase_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || restart || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R3: a tick only occurs while the channel runs
    a_r3_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    // R3: code 0 ticks on every running cycle
    a_r3_code0_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && code == '0) |-> tick);

endmodule

// File: rtl/ostmr_event_chan.sv
module ostmr_event_chan #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             cnt_clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             enabled,
    output logic             hit
);
    import ostmr_pkg::*;

    ev_state_t        state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             at_cmp;

    assign at_cmp = (count_q == cmp);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_OFF: begin
                if (en_set) state_d = EV_RUN;              // ENABLE
            end
            EV_RUN: begin
                if (en_clr)       state_d = EV_OFF;        // DISABLE
                else if (cnt_clr) state_d = EV_RUN;        // RESTART
                else if (at_cmp)  state_d = EV_DONE;       // MATCH
            end
            EV_DONE: begin
                if (en_clr)       state_d = EV_OFF;        // DISABLE
                else if (cnt_clr) state_d = EV_RUN;        // RESTART
            end
            default: state_d = EV_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_OFF;
        else        state_q <= state_d;
    end

    // counter: clear beats counting, no count on the matching cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_clr) begin
            count_q <= '0;
        end else if (state_q == EV_RUN && tick && !at_cmp) begin
            count_q <= count_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        count   = count_q;
        running = (state_q == EV_RUN);
        enabled = (state_q != EV_OFF);
        hit     = (state_q == EV_RUN) && at_cmp && !cnt_clr && !en_clr;
    end

    a_r5_ev_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (count_q == '0));

    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EV_DONE && !cnt_clr) |=> $stable(count_q));

    a_r6_match_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (state_q == EV_DONE));

    a_r10_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> (state_q == EV_OFF));

    a_r10_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EV_OFF && !cnt_clr) |=> $stable(count_q));

endmodule

// File: rtl/ostmr_free_chan.sv
module ostmr_free_chan #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             cnt_clr,
    input  logic             tick,
    input  logic             rd_lo,
    output logic [CNT_W-1:0] count_lo,
    output logic [CNT_W-1:0] hi_buf,
    output logic             running,
    output logic             enabled
);
    import ostmr_pkg::*;

    localparam int unsigned WIDE_W = 2 * CNT_W;

    fr_state_t         state_q, state_d;
    logic [WIDE_W-1:0] count_q;
    logic [CNT_W-1:0]  hbuf_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_OFF: if (en_set) state_d = FR_RUN;          // ENABLE
            FR_RUN: if (en_clr) state_d = FR_OFF;          // DISABLE
            default: state_d = FR_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_clr) begin
            count_q <= '0;
        end else if (state_q == FR_RUN && tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hbuf_q <= '0;
        else if (rd_lo) hbuf_q <= count_q[WIDE_W-1:CNT_W];
    end

    always_comb begin
        count_lo = count_q[CNT_W-1:0];
        hi_buf   = hbuf_q;
        running  = (state_q == FR_RUN);
        enabled  = (state_q == FR_RUN);
    end

    a_r5_tb_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (count_q == '0));

    a_r9_hbuf_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (hbuf_q == $past(count_q[WIDE_W-1:CNT_W])));

    a_r4_tb_disable: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> (state_q == FR_OFF));

endmodule

// File: rtl/os_timer_duo.sv
module os_timer_duo #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import ostmr_pkg::*;

    localparam int unsigned CTRL_W = NUM_CH * CODE_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] cmp_q;
    logic              flag_q;
    logic              mask_q;

    logic [NUM_CH-1:0] en_set, en_clr, cnt_clr;
    logic [NUM_CH-1:0] ch_run, ch_tick, ch_en;

    logic              ev_hit;
    logic              rd_lo;
    logic [DATA_W-1:0] ev_count, tb_lo, tb_hi;

    logic wr_ctrl, wr_clr, wr_flag, wr_mask, wr_cmp, wr_eset, wr_eclr;

    // write decode
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_clr  = bus_wr && (bus_addr == ADDR_W'(OFS_CLR));
        wr_flag = bus_wr && (bus_addr == ADDR_W'(OFS_FLAG));
        wr_mask = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
        wr_cmp  = bus_wr && (bus_addr == ADDR_W'(OFS_CMP));
        wr_eset = bus_wr && (bus_addr == ADDR_W'(OFS_ESET));
        wr_eclr = bus_wr && (bus_addr == ADDR_W'(OFS_ECLR));
        en_set  = wr_eset ? bus_wdata[NUM_CH-1:0] : '0;
        en_clr  = wr_eclr ? bus_wdata[NUM_CH-1:0] : '0;
        cnt_clr = wr_clr  ? bus_wdata[NUM_CH-1:0] : '0;
        rd_lo   = bus_rd && (bus_addr == ADDR_W'(OFS_TBLO));
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
            mask_q <= 1'b1;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (wr_cmp)  cmp_q  <= bus_wdata;
            if (wr_mask) mask_q <= bus_wdata[0];
        end
    end

    // compare flag: a match beats a software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (ev_hit) begin
            flag_q <= 1'b1;
        end else if (wr_flag && !bus_wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    // one prescaler per channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_pre
        ostmr_prescaler #(
            .CODE_W (CODE_W),
            .PH_W   (PH_W)
        ) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (ch_run[g]),
            .restart (cnt_clr[g]),
            .code    (ctrl_q[g*CODE_W +: CODE_W]),
            .tick    (ch_tick[g])
        );
    end

    ostmr_event_chan #(.CNT_W(DATA_W)) u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_set  (en_set[CH_EVENT]),
        .en_clr  (en_clr[CH_EVENT]),
        .cnt_clr (cnt_clr[CH_EVENT]),
        .tick    (ch_tick[CH_EVENT]),
        .cmp     (cmp_q),
        .count   (ev_count),
        .running (ch_run[CH_EVENT]),
        .enabled (ch_en[CH_EVENT]),
        .hit     (ev_hit)
    );

    ostmr_free_chan #(.CNT_W(DATA_W)) u_tbase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set   (en_set[CH_TBASE]),
        .en_clr   (en_clr[CH_TBASE]),
        .cnt_clr  (cnt_clr[CH_TBASE]),
        .tick     (ch_tick[CH_TBASE]),
        .rd_lo    (rd_lo),
        .count_lo (tb_lo),
        .hi_buf   (tb_hi),
        .running  (ch_run[CH_TBASE]),
        .enabled  (ch_en[CH_TBASE])
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_W'(OFS_CTRL):  bus_rdata = DATA_W'(ctrl_q);
                ADDR_W'(OFS_FLAG):  bus_rdata = DATA_W'(flag_q);
                ADDR_W'(OFS_MASK):  bus_rdata = DATA_W'(mask_q);
                ADDR_W'(OFS_CMP):   bus_rdata = cmp_q;
                ADDR_W'(OFS_EVCNT): bus_rdata = ev_count;
                ADDR_W'(OFS_TBLO):  bus_rdata = tb_lo;
                ADDR_W'(OFS_TBHI):  bus_rdata = tb_hi;
                ADDR_W'(OFS_ESET):  bus_rdata = DATA_W'(ch_en);
                default:            bus_rdata = '0;
            endcase
        end
    end

    assign irq = flag_q && !mask_q;

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit |=> flag_q);

    a_r7_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && bus_wdata[0] && flag_q) |=> flag_q);

    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !irq);

    a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/os_timer_duo_bench.sv
module os_timer_duo_bench;

    localparam logic [7:0] A_CTRL = 8'h00, A_CLR = 8'h08, A_FLAG = 8'h0C,
                           A_MASK = 8'h10, A_CMP = 8'h14, A_EVC = 8'h18,
                           A_TBL  = 8'h20, A_TBH = 8'h24, A_ESET = 8'h34,
                           A_ECLR = 8'h38;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [3:0] ctrl_sh = '0;

    always #10 clk = ~clk;

    os_timer_duo u_os_timer_duo (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic int unsigned divisor(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 4 : 16;
    endfunction

    function automatic logic [31:0] exp_count(input int unsigned n, input logic [1:0] code);
        return 32'(n / divisor(code));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic rd_edge(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic step(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm_event(input logic [1:0] code, input logic [31:0] cmp);
        wr(A_ECLR, 32'h1);
        ctrl_sh[1:0] = code;
        wr(A_CTRL, {28'h0, ctrl_sh});
        wr(A_FLAG, 32'h0);
        wr(A_CMP, cmp);
        wr(A_CLR, 32'h1);
        wr(A_ESET, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v0;
        void'($urandom(32'd20240611));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        peek(A_CTRL, v); check("R1 ctrl", v, 0);
        peek(A_FLAG, v); check("R1 flag", v, 0);
        peek(A_MASK, v); check("R1 mask", v, 1);
        peek(A_ESET, v); check("R1 enables", v, 0);
        peek(A_EVC, v);  check("R1 event count", v, 0);
        peek(A_TBL, v);  check("R1 tbase count", v, 0);
        check("R1 irq", 32'(irq), 0);

        // R2 decode
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        peek(A_CTRL, v); check("R2 stray write ignored ctrl", v, 0);
        peek(A_ESET, v); check("R2 stray write ignored en", v, 0);
        peek(8'h40, v);  check("R2 unmapped read", v, 0);
        peek(8'h04, v);  check("R2 hole read", v, 0);
        peek(A_CLR, v);  check("R2 clear reads zero", v, 0);

        // R4 enables
        wr(A_ESET, 32'h0); step(5);
        peek(A_ESET, v); check("R4 zero set no effect", v, 0);
        peek(A_TBL, v);  check("R4 idle tbase", v, 0);
        wr(A_ESET, 32'h2);
        peek(A_ESET, v); check("R4 tbase enabled", v, 2);
        step(7);
        peek(A_TBL, v);  check("R3 code0 rate", v, 7);

        // R5 clear wins over a tick on the same edge
        wr(A_CLR, 32'h2);
        peek(A_TBL, v);  check("R5 tbase clear wins", v, 0);
        step(4);
        peek(A_TBL, v);  check("R5 tbase after clear", v, 4);

        // R9 high buffer
        rd_edge(A_TBL, v); check("R9 low read", v, 4);
        peek(A_TBH, v);    check("R9 high buffer", v, 0);

        // R3 code 3 and code 1 on time base
        ctrl_sh[3:2] = 2'd3; wr(A_CTRL, {28'h0, ctrl_sh});
        wr(A_CLR, 32'h2); step(40);
        peek(A_TBL, v);  check("R3 code3 div16", v, 2);
        ctrl_sh[3:2] = 2'd1; wr(A_CTRL, {28'h0, ctrl_sh});
        wr(A_CLR, 32'h2); step(13);
        peek(A_TBL, v);  check("R3 code1 div4", v, 3);

        // R4 disable freezes
        wr(A_ECLR, 32'h2);
        peek(A_TBL, v0); step(10);
        peek(A_TBL, v);  check("R4 tbase frozen", v, v0);
        peek(A_ESET, v); check("R4 tbase disabled", v, 0);
        wr(A_ESET, 32'h2);

        // R8 mask and R6 one-shot
        arm_event(2'd0, 32'd2);
        step(5);
        peek(A_FLAG, v); check("R6 flag set", v, 1);
        check("R8 masked irq low", 32'(irq), 0);
        wr(A_MASK, 32'h0); check("R8 unmasked irq high", 32'(irq), 1);
        wr(A_MASK, 32'h1); check("R8 remasked irq low", 32'(irq), 0);
        wr(A_MASK, 32'h0);

        // R7 flag writes
        wr(A_FLAG, 32'h1);
        peek(A_FLAG, v); check("R7 write one keeps", v, 1);
        wr(A_FLAG, 32'hFFFF_FFFE);
        peek(A_FLAG, v); check("R7 write zero clears", v, 0);
        check("R7 irq after clear", 32'(irq), 0);

        // R6 hold in EV_DONE
        peek(A_EVC, v);  check("R6 count at compare", v, 2);
        step(10);
        peek(A_EVC, v);  check("R6 count holds", v, 2);
        peek(A_ESET, v); check("R6 still enabled", v, 3);

        // R10 restart from EV_DONE
        wr(A_CLR, 32'h1);
        peek(A_EVC, v);  check("R10 restart zero", v, 0);
        step(2);
        check("R10 irq before rematch", 32'(irq), 0);
        peek(A_EVC, v);  check("R10 count after restart", v, 2);
        step(1);
        check("R10 irq on rematch", 32'(irq), 1);

        // R7 match and clear on the same edge
        arm_event(2'd0, 32'd5);
        check("R7 armed irq low", 32'(irq), 0);
        step(5);
        wr(A_FLAG, 32'h0);
        check("R7 set wins over clear", 32'(irq), 1);
        wr(A_FLAG, 32'h0);
        check("R7 cleared afterwards", 32'(irq), 0);

        // R5 event clear wins, R10 disable and resume
        arm_event(2'd0, 32'hFFFF_FFFF);
        step(6);
        peek(A_EVC, v);  check("R3 event code0 count", v, 6);
        wr(A_CLR, 32'h1);
        peek(A_EVC, v);  check("R5 event clear wins", v, 0);
        wr(A_ECLR, 32'h1);
        peek(A_ESET, v); check("R10 event disabled", v, 2);
        peek(A_EVC, v0); step(3);
        peek(A_EVC, v);  check("R10 frozen while off", v, v0);
        wr(A_ESET, 32'h1); step(2);
        peek(A_EVC, v);  check("R10 resume from held", v, v0 + 2);

        // random one-shot runs: R3 R6 R8
        for (int i = 0; i < 12; i++) begin
            logic [1:0]  code;
            int unsigned cmp;
            code = 2'($urandom % 3);
            cmp  = $urandom % 10;
            arm_event(code, 32'(cmp));
            step(cmp * divisor(code));
            check("R6 random irq before match", 32'(irq), 0);
            step(1);
            check("R8 random irq at match", 32'(irq), 1);
            step(7);
            peek(A_EVC, v); check("R6 random hold", v, 32'(cmp));
        end

        // random time-base rates: R3
        for (int i = 0; i < 12; i++) begin
            logic [1:0]  code;
            int unsigned n;
            code = 2'($urandom % 3);
            n    = 1 + ($urandom % 60);
            ctrl_sh[3:2] = code;
            wr(A_CTRL, {28'h0, ctrl_sh});
            wr(A_CLR, 32'h2);
            step(n);
            peek(A_TBL, v); check("R3 random tbase rate", v, exp_count(n, code));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule